// File: doc/BRIEF.md
# I2C Command Tag Stream Generator

This block turns one I2C message request into the byte stream that an I2C master engine reads from its output FIFO: command tags, address bytes, length codes and, for writes, the payload. A request names a 7- or 10-bit target address, the direction, whether the transfer runs in high-speed mode, and the message length in bytes. Write payload arrives on a separate byte stream with valid/ready flow control.

The message is split into chunks of up to 256 bytes. The first chunk opens with a start preamble and the address. Every chunk then carries a data tag and a one-byte length code. For writes, the chunk's payload follows its length code. The resulting bytes are packed four to a 32-bit word, least-significant byte first, and presented on a valid/ready output. A one-cycle done pulse marks the acceptance of the final word. A new request is taken only when the previous message has fully left the block. The length of a request must be at least 1.

Top module: `i2c_tag_streamer`

## Requirements
- R1: The first chunk begins with the start tag 0x81 followed by the address byte {addr[6:0], read}, where read is 1 for a read and 0 for a write.
- R2: When the high-speed flag is set, the first chunk's preamble is 0x81, 0xFF, 0x81, then the address byte(s).
- R3: When the 10-bit flag is set, a second address byte {5'b0, addr[9:7]} follows the first address byte.
- R4: A message of len bytes is cut into ceil(len/256) chunks. Every chunk except the last carries data tag 0x82 (write) or 0x85 (read). The last chunk carries 0x83 (write) or 0x87 (read).
- R5: Each data tag is followed by one length byte: 0x00 for a full 256-byte chunk, and len mod 256 for the last chunk, which is 0x00 when len is a multiple of 256.
- R6: For a write, each chunk's length byte is followed directly by that chunk's payload bytes, taken in order from the write stream. For a read, no payload is emitted and the write stream is never made ready.
- R7: Output bytes are packed into 32-bit words, with byte n of the stream in bits [8*(n mod 4)+7 : 8*(n mod 4)]. Unused bytes of the final word are 0.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: req_ready is high only while no message is in progress. It goes low the cycle after a request is accepted and stays low until the last word has been accepted.
- R10: done pulses high for exactly one cycle, in the cycle after the final word is accepted, and req_ready is high in that cycle.
- R11: After reset, out_valid, wr_ready and done are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Message request valid |
| req_ready | output | 1 | Block idle; request accepted when both are high |
| req_addr | input | 10 | Target address (bits 9:7 used only in 10-bit mode) |
| req_ten_bit | input | 1 | 10-bit addressing |
| req_read | input | 1 | 1 = read message, 0 = write message |
| req_hs | input | 1 | High-speed preamble |
| req_len | input | LEN_W | Message length in bytes (at least 1) |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Payload byte valid |
| wr_ready | output | 1 | Payload byte taken when both are high |
| out_data | output | 8*WORD_BYTES | Packed output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted when both are high |
| done | output | 1 | One-cycle pulse after the final word is accepted |

## Verification
The assertions check the handshake rules on every cycle. They check that a held word stays stable under backpressure, that req_ready drops after acceptance and stays low while words are pending, that the payload stream is never ready while the block is idle, and that done is a single-cycle pulse raised only when the block is idle again. The byte contents are checked only by the bench's scenarios, against a model built from the requirements. These contents are the tag choice, the preamble variants, the chunk count, the length codes including the exact-multiple case, the placement of payload, and the byte lanes and padding. The scenarios also throttle both streams so that chunk boundaries fall across stalls.

// File: rtl/i2c_tag_pkg.sv
package i2c_tag_pkg;

  localparam int CHUNK_BYTES = 256;

  localparam logic [7:0] TAG_START   = 8'h81;
  localparam logic [7:0] TAG_HS      = 8'hFF;
  localparam logic [7:0] TAG_WR      = 8'h82;
  localparam logic [7:0] TAG_WR_STOP = 8'h83;
  localparam logic [7:0] TAG_RD      = 8'h85;
  localparam logic [7:0] TAG_RD_STOP = 8'h87;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_HS,
    S_RESTART,
    S_ADDR_LO,
    S_ADDR_HI,
    S_TAG,
    S_LEN,
    S_DATA
  } seq_state_t;

endpackage

// File: rtl/i2c_tag_seq.sv
module i2c_tag_seq
  import i2c_tag_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [9:0]       addr,
  input  logic             ten_bit,
  input  logic             rd,
  input  logic             hs,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       byte_data,
  output logic             byte_valid,
  output logic             byte_last,
  input  logic             byte_ready
);

  localparam int CL_W = $clog2(CHUNK_BYTES) + 1;

  seq_state_t       state;
  logic [9:0]       addr_q;
  logic             ten_q, rd_q, hs_q;
  logic [LEN_W-1:0] rem;
  logic [CL_W-1:0]  chunk_left;
  logic             last_chunk;
  logic [CL_W-1:0]  this_chunk;
  logic             fire;

  assign last_chunk = (rem <= LEN_W'(CHUNK_BYTES));
  assign this_chunk = last_chunk ? rem[CL_W-1:0] : CL_W'(CHUNK_BYTES);
  assign wr_ready   = (state == S_DATA) && byte_ready;
  assign fire       = byte_valid && byte_ready;

  always_comb begin
    byte_data  = 8'h00;
    byte_valid = (state != S_IDLE);
    byte_last  = 1'b0;
    case (state)
      S_START, S_RESTART: byte_data = TAG_START;
      S_HS:               byte_data = TAG_HS;
      S_ADDR_LO:          byte_data = {addr_q[6:0], rd_q};
      S_ADDR_HI:          byte_data = {5'b00000, addr_q[9:7]};
      S_TAG: begin
        if (rd_q) byte_data = last_chunk ? TAG_RD_STOP : TAG_RD;
        else      byte_data = last_chunk ? TAG_WR_STOP : TAG_WR;
      end
      S_LEN: begin
        byte_data = last_chunk ? rem[7:0] : 8'h00;
        byte_last = rd_q && last_chunk;
      end
      S_DATA: begin
        byte_data  = wr_data;
        byte_valid = wr_valid;
        byte_last  = (rem == LEN_W'(1));
      end
      default: byte_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      addr_q     <= '0;
      ten_q      <= 1'b0;
      rd_q       <= 1'b0;
      hs_q       <= 1'b0;
      rem        <= '0;
      chunk_left <= '0;
    end else if (state == S_IDLE) begin
      if (start) begin
        addr_q <= addr;
        ten_q  <= ten_bit;
        rd_q   <= rd;
        hs_q   <= hs;
        rem    <= len;
        state  <= S_START;
      end
    end else if (fire) begin
      case (state)
        S_START:   state <= hs_q ? S_HS : S_ADDR_LO;
        S_HS:      state <= S_RESTART;
        S_RESTART: state <= S_ADDR_LO;
        S_ADDR_LO: state <= ten_q ? S_ADDR_HI : S_TAG;
        S_ADDR_HI: state <= S_TAG;
        S_TAG:     state <= S_LEN;
        S_LEN: begin
          chunk_left <= this_chunk;
          if (rd_q) begin
            rem   <= rem - LEN_W'(this_chunk);
            state <= last_chunk ? S_IDLE : S_TAG;
          end else begin
            state <= S_DATA;
          end
        end
        S_DATA: begin
          rem        <= rem - LEN_W'(1);
          chunk_left <= chunk_left - CL_W'(1);
          if (rem == LEN_W'(1))              state <= S_IDLE;
          else if (chunk_left == CL_W'(1))   state <= S_TAG;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_word_packer.sv
module i2c_word_packer #(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              in_byte,
  input  logic                    in_valid,
  input  logic                    in_last,
  output logic                    in_ready,
  output logic [8*WORD_BYTES-1:0] out_data,
  output logic                    out_valid,
  output logic                    out_last,
  input  logic                    out_ready
);

  localparam int CNT_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam int W     = 8 * WORD_BYTES;

  logic [CNT_W-1:0] fill;
  logic [W-1:0]     acc;
  logic [W-1:0]     merged;

  assign in_ready = !out_valid || out_ready;

  always_comb begin
    merged = acc;
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (fill == CNT_W'(i)) merged[8*i +: 8] = in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      acc       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (in_valid && in_ready) begin
        if (fill == CNT_W'(WORD_BYTES - 1) || in_last) begin
          out_data  <= merged;
          out_valid <= 1'b1;
          out_last  <= in_last;
          acc       <= '0;
          fill      <= '0;
        end else begin
          acc  <= merged;
          fill <= fill + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/i2c_tag_streamer.sv
module i2c_tag_streamer #(
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [9:0]              req_addr,
  input  logic                    req_ten_bit,
  input  logic                    req_read,
  input  logic                    req_hs,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [7:0]              wr_data,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  output logic [8*WORD_BYTES-1:0] out_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    done
);

  logic       busy;
  logic       start;
  logic [7:0] b_data;
  logic       b_valid, b_last, b_ready;
  logic       w_last;
  logic       final_fire;

  assign req_ready  = !busy;
  assign start      = req_valid && !busy;
  assign final_fire = out_valid && out_ready && w_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= final_fire;
      if (start)           busy <= 1'b1;
      else if (final_fire) busy <= 1'b0;
    end
  end

  i2c_tag_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .addr       (req_addr),
    .ten_bit    (req_ten_bit),
    .rd         (req_read),
    .hs         (req_hs),
    .len        (req_len),
    .wr_data    (wr_data),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .byte_data  (b_data),
    .byte_valid (b_valid),
    .byte_last  (b_last),
    .byte_ready (b_ready)
  );

  i2c_word_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .in_byte   (b_data),
    .in_valid  (b_valid),
    .in_last   (b_last),
    .in_ready  (b_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (w_last),
    .out_ready (out_ready)
  );

endmodule

// File: rtl/i2c_tag_streamer_chk.sv
module i2c_tag_streamer_chk #(
  parameter int WORD_BYTES = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    wr_ready,
  input logic [8*WORD_BYTES-1:0] out_data,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    done
);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_req_block_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_out_busy_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready);

  assert_no_payload_idle_R6: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !wr_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

endmodule

bind i2c_tag_streamer i2c_tag_streamer_chk #(.WORD_BYTES(WORD_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_ready  (wr_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .done      (done)
);

// File: tb/i2c_tag_streamer_tb.sv
module i2c_tag_streamer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [9:0]       req_addr = '0;
  logic             req_ten_bit = 1'b0;
  logic             req_read = 1'b0;
  logic             req_hs = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0]       wr_data = '0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [31:0]      out_data;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic             done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tag_streamer #(.LEN_W(LEN_W), .WORD_BYTES(4)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ten_bit(req_ten_bit), .req_read(req_read),
    .req_hs(req_hs), .req_len(req_len), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .done(done)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(int i, logic [9:0] a);
    return 8'((i * 7) + int'(a) + 3);
  endfunction

  task automatic run_msg(string req, logic [9:0] a, bit ten, bit rd, bit hs,
                         int len, bit stall);
    logic [7:0]  q[$];
    logic [31:0] ew[$];
    int nch;
    nch = (len + 255) / 256;
    for (int c = 0; c < nch; c++) begin
      int  clen;
      bit  lastc;
      lastc = (c == nch - 1);
      clen  = lastc ? (len - 256 * c) : 256;
      if (c == 0) begin
        q.push_back(8'h81);
        if (hs) begin q.push_back(8'hFF); q.push_back(8'h81); end
        q.push_back({a[6:0], rd});
        if (ten) q.push_back({5'b0, a[9:7]});
      end
      q.push_back(rd ? (lastc ? 8'h87 : 8'h85) : (lastc ? 8'h83 : 8'h82));
      q.push_back(8'(clen % 256));
      if (!rd) for (int i = 0; i < clen; i++) q.push_back(pay(256 * c + i, a));
    end
    for (int i = 0; i < q.size(); i += 4) begin
      logic [31:0] w;
      w = '0;
      for (int j = 0; j < 4; j++) if (i + j < q.size()) w[8*j +: 8] = q[i+j];
      ew.push_back(w);
    end

    @(negedge clk);
    req_addr = a; req_ten_bit = ten; req_read = rd; req_hs = hs;
    req_len = LEN_W'(len); req_valid = 1'b1;
    check(req_ready == 1'b1, {req, " R9 idle before request"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {req, " R9 busy after accept"}, 32'(req_ready), 32'd0);

    fork
      begin : feeder
        int k = 0;
        int cyc = 0;
        int npay = rd ? 0 : len;
        while (k < npay) begin
          @(negedge clk);
          cyc++;
          wr_data  = pay(k, a);
          wr_valid = !stall || (cyc % 4 != 1);
          #2;
          if (!rd && wr_ready) check(1'b1, {req, " R6"}, 0, 0);
          if (rd && wr_ready) check(1'b0, {req, " R6 read must not take payload"}, 1, 0);
          if (wr_valid && wr_ready) k++;
        end
        @(negedge clk);
        wr_valid = 1'b0;
      end
      begin : consumer
        int wi = 0;
        int cyc = 0;
        bit held = 0;
        logic [31:0] hv = '0;
        while (wi < ew.size()) begin
          @(negedge clk);
          cyc++;
          if (held) check(out_valid && out_data == hv, {req, " R8 hold"}, out_data, hv);
          out_ready = !stall || (cyc % 3 != 0);
          #1;
          if (rd) check(wr_ready == 1'b0, {req, " R6 no payload on read"}, 32'(wr_ready), 0);
          held = out_valid && !out_ready;
          hv   = out_data;
          if (out_valid && out_ready) begin
            check(out_data == ew[wi], {req, " R7 word"}, out_data, ew[wi]);
            wi++;
          end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(done == 1'b1, {req, " R10 done pulse"}, 32'(done), 1);
        check(req_ready == 1'b1, {req, " R10 idle at done"}, 32'(req_ready), 1);
        @(negedge clk);
        check(done == 1'b0, {req, " R10 single cycle"}, 32'(done), 0);
        check(out_valid == 1'b0, {req, " R7 no extra word"}, 32'(out_valid), 0);
      end
    join
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 0);
    check(wr_ready == 1'b0, "R11 wr_ready", 32'(wr_ready), 0);
    check(done == 1'b0, "R11 done", 32'(done), 0);
    check(req_ready == 1'b1, "R11 req_ready", 32'(req_ready), 1);
  endtask

  task automatic test_short_write();  run_msg("R1 R4 R5 R6 short write", 10'h05A, 0, 0, 0, 5, 0);   endtask
  task automatic test_hs_read();      run_msg("R2 R1 R6 hs read", 10'h033, 0, 1, 1, 3, 0);        endtask
  task automatic test_ten_long_wr();  run_msg("R3 R4 R5 R8 10-bit write", 10'h2C5, 1, 0, 0, 300, 1); endtask
  task automatic test_exact_read();   run_msg("R5 R4 exact read", 10'h011, 0, 1, 0, 512, 1);      endtask
  task automatic test_exact_write();  run_msg("R5 R2 R3 exact write", 10'h3FF, 1, 0, 1, 256, 0);  endtask
  task automatic test_pad();          run_msg("R7 pad write", 10'h048, 0, 0, 0, 1, 1);           endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_short_write();
    test_hs_read();
    test_ten_long_wr();
    test_exact_read();
    test_exact_write();
    test_pad();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule